// File: doc/BRIEF.md
# Byte-lane asynchronous static RAM controller

This block connects an on-chip requester to an external asynchronous static RAM organised as 64K words of 16 bits, with a separate active-low enable for each 8-bit lane. The requester presents one request at a time: a read or write flag, a word address, write data and a lane mask. A read returns its data together with a one-cycle valid strobe. Every memory-side control line is produced by a register. The tri-state data bus is handled through a separate out value, in value and drive-enable signal, so the pad buffer can live outside the block.

Timing on the memory side is counted in clock cycles, and three parameters set the counts. The first is the length of the write pulse. The second is the read access wait. The third is the number of idle cycles between a read and a following write. Output enable stays high for the whole of every write. The memory's drivers are therefore already off while the write runs, and only the minimum write-pulse width has to be met.

The request side is valid/ready. `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the requester must hold its request stable. There is no back-pressure on the response: `rsp_valid` is a single-cycle pulse that the requester must take when it appears.

Top module: `sram_ctl`

## Requirements
- R1: After reset the memory is deselected. Chip select, output enable, write enable and both lane enables are high (inactive), the bus drive enable is low, `rsp_valid` is low and `req_ready` is high.
- R2: `req_ready` is high only in idle. It falls on the edge that accepts a request and stays low until that operation has completed.
- R3: A read holds chip select and output enable low and write enable high for exactly RD_WAIT cycles, with lane enables equal to the inverse of the mask. `rsp_valid` is high for exactly one cycle, the (RD_WAIT+1)-th cycle after the accepting edge.
- R4: Read data on a lane whose mask bit is 1 is the stored byte. A lane whose mask bit is 0 returns zero. Mask bit 0 maps to bits 7..0 and mask bit 1 to bits 15..8.
- R5: A write drives write enable low for exactly WR_PULSE consecutive cycles. Chip select is low during the pulse, and output enable stays high for the whole time chip select is low.
- R6: The bus drive enable rises one cycle before write enable falls and drops one cycle after write enable rises. It is never high while output enable is low.
- R7: On a write, lane enables equal the inverse of the mask for the whole time chip select is low. A single-lane write therefore leaves the other byte of the word unchanged.
- R8: Address and lane enables stay stable for the whole time chip select is low, including the edge on which write enable rises.
- R9: A write accepted directly after a read first spends TURN cycles with chip select high. A write after a write, or after reset, drops chip select in the first cycle after acceptance.
- R10: Chip select is high, and write and output enable are inactive, whenever the controller is idle.
- R11: A request with mask 00 runs its normal sequence with both lane enables high. It stores nothing, and a read of that kind returns zero with its valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_be_n | output | 2 | Memory lane enables, active low, bit 0 = low byte |
| mem_addr | output | 16 | Memory address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_in | input | 16 | Data seen on the memory bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |

## Verification
A wrong sequencer state appears on the memory control pins in the very next cycle, because each of them is a register loaded from the next state. The bench counts cycles against the pins. A miscounted timer shows up as a write pulse or read window of the wrong length, or as a response strobe at the wrong cycle. A lost turnaround flag moves the write's chip select earlier by TURN cycles. Wrong lane state does not always show on the pins during the operation itself: a wrong lane enable corrupts the other byte, and that appears only when the word is read back. The memory model also counts any cycle in which the controller and the memory drive the bus together.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_TURN  = 3'd1,
    ST_SETUP = 3'd2,
    ST_PULSE = 3'd3,
    ST_HOLD  = 3'd4,
    ST_READ  = 3'd5
  } sram_st_e;

  function automatic logic st_selects(input sram_st_e s);
    return (s == ST_SETUP) || (s == ST_PULSE) || (s == ST_HOLD) || (s == ST_READ);
  endfunction

  function automatic logic st_drives_bus(input sram_st_e s);
    return (s == ST_SETUP) || (s == ST_PULSE) || (s == ST_HOLD);
  endfunction
endpackage

// File: rtl/sram_ctl_cnt.sv
module sram_ctl_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_ctl_lane.sv
module sram_ctl_lane #(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          lane_en,
  input  logic [LW-1:0] din,
  output logic [LW-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dout <= '0;
    else if (capture) dout <= lane_en ? din : '0;
  end
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int LANES    = 2,
  parameter int WR_PULSE = 1,
  parameter int RD_WAIT  = 2,
  parameter int TURN     = 1,
  parameter int CNT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              req_ready,
  input  logic              cnt_zero,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              capture,
  output logic              rsp_valid,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe
);
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WP_LD   = CNT_W'(WR_PULSE - 1);
  localparam logic [CNT_W-1:0] TURN_LD = CNT_W'((TURN > 0) ? TURN - 1 : 0);
  localparam bit               HAS_TURN = (TURN > 0);

  sram_st_e             st_q, st_n;
  logic                 last_rd_q;
  logic [LANES-1:0]     mask_q;
  logic                 accept;
  logic [LANES-1:0]     mask_sel;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mask_sel  = accept ? req_mask : mask_q;

  always_comb begin
    st_n     = st_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    capture  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (!req_write) begin
            st_n     = ST_READ;
            cnt_load = 1'b1;
            cnt_val  = RD_LD;
          end else if (HAS_TURN && last_rd_q) begin
            st_n     = ST_TURN;
            cnt_load = 1'b1;
            cnt_val  = TURN_LD;
          end else begin
            st_n = ST_SETUP;
          end
        end
      end
      ST_TURN:  if (cnt_zero) st_n = ST_SETUP;
      ST_SETUP: begin
        st_n     = ST_PULSE;
        cnt_load = 1'b1;
        cnt_val  = WP_LD;
      end
      ST_PULSE: if (cnt_zero) st_n = ST_HOLD;
      ST_HOLD:  st_n = ST_IDLE;
      ST_READ: begin
        if (cnt_zero) begin
          capture = 1'b1;
          st_n    = ST_IDLE;
        end
      end
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      last_rd_q  <= 1'b0;
      mask_q     <= '0;
      rsp_valid  <= 1'b0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_dq_oe  <= 1'b0;
    end else begin
      st_q      <= st_n;
      rsp_valid <= capture;
      if (accept) begin
        last_rd_q <= !req_write;
        mask_q    <= req_mask;
        mem_addr  <= req_addr;
        if (req_write) mem_dq_out <= req_wdata;
      end
      mem_cs_n  <= !st_selects(st_n);
      mem_oe_n  <= (st_n != ST_READ);
      mem_we_n  <= (st_n != ST_PULSE);
      mem_dq_oe <= st_drives_bus(st_n);
      mem_be_n  <= st_selects(st_n) ? ~mask_sel : '1;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int WR_PULSE = 1,
  parameter int RD_WAIT  = 2,
  parameter int TURN     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);
  localparam int LANES   = DATA_W / 8;
  localparam int MAX_CNT = (WR_PULSE > RD_WAIT) ? ((WR_PULSE > TURN) ? WR_PULSE : TURN)
                                                : ((RD_WAIT > TURN) ? RD_WAIT : TURN);
  localparam int CNT_W   = (MAX_CNT > 1) ? $clog2(MAX_CNT) : 1;

  logic             cnt_zero;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             capture;

  sram_ctl_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES),
    .WR_PULSE(WR_PULSE), .RD_WAIT(RD_WAIT), .TURN(TURN), .CNT_W(CNT_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .req_ready(req_ready),
    .cnt_zero(cnt_zero), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .capture(capture), .rsp_valid(rsp_valid),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe)
  );

  sram_ctl_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sram_ctl_lane #(.LW(8)) u_lane (
      .clk(clk), .rst_n(rst_n), .capture(capture),
      .lane_en(~mem_be_n[l]),
      .din(mem_dq_in[8*l +: 8]),
      .dout(rsp_rdata[8*l +: 8])
    );
  end
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int ADDR_W   = 16,
  parameter int LANES    = 2,
  parameter int WR_PULSE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);
  int we_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        we_run <= 0;
    else if (!mem_we_n) we_run <= we_run + 1;
    else               we_run <= 0;
  end

  // R2 / R10: idle means deselected
  a_r10_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n));

  // R3: read drive only with chip selected and write inactive
  a_r3_read_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_cs_n && mem_we_n));

  // R3: response strobe lasts one cycle
  a_r3_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5: write pulse only with chip selected, output enable high, bus driven
  a_r5_write_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

  // R5: pulse width counted
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == WR_PULSE));

  // R6: drive enable leads and trails write enable
  a_r6_oe_leads: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(mem_dq_oe));
  a_r6_oe_trails: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  // R8: address and lane enables stable while selected
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));
endmodule

bind sram_ctl sram_ctl_chk #(
  .ADDR_W(ADDR_W), .LANES(LANES), .WR_PULSE(WR_PULSE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_ctl.sv
module test_sram_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int WP = 1;
  localparam int RW = 2;
  localparam int TA = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_addr, mem_dq_out, mem_dq_in;

  int checks = 0;
  int failures = 0;
  int conflicts = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;
  logic [15:0] model_mem [int];
  logic [15:0] shadow [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctl #(.WR_PULSE(WP), .RD_WAIT(RW), .TURN(TA)) i_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // behavioural memory: drives enabled lanes on read, undriven lanes float to A5
  always_comb begin
    logic [15:0] word;
    word = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
    for (int l = 0; l < 2; l++) begin
      if (mem_dq_oe)
        mem_dq_in[8*l +: 8] = mem_dq_out[8*l +: 8];
      else if (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_be_n[l])
        mem_dq_in[8*l +: 8] = word[8*l +: 8];
      else
        mem_dq_in[8*l +: 8] = 8'hA5;
    end
  end

  always @(posedge mem_we_n) begin
    if (model_on && !mem_cs_n) begin
      logic [15:0] w;
      w = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 16'h0000;
      for (int l = 0; l < 2; l++)
        if (!mem_be_n[l]) w[8*l +: 8] = mem_dq_out[8*l +: 8];
      model_mem[int'(mem_addr)] = w;
    end
  end

  always @(negedge clk) begin
    if (model_on && mem_dq_oe && !mem_cs_n && !mem_oe_n && mem_we_n && (mem_be_n != 2'b11))
      conflicts++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    check(mem_cs_n && mem_oe_n && mem_we_n, "R1", "controls inactive",
          {mem_cs_n, mem_oe_n, mem_we_n}, 3'b111);
    check(mem_be_n == 2'b11, "R1", "lane enables", mem_be_n, 2'b11);
    check(!mem_dq_oe && !rsp_valid, "R1", "drive/strobe low", {mem_dq_oe, rsp_valid}, 0);
    check(req_ready, "R1", "ready", req_ready, 1);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] m, input int lead);
    int we_lo = 0, first_cs = -1, first_we = -1, last_we = -1, first_oe = -1, last_oe = -1;
    bit oe_bad = 0, be_bad = 0, addr_bad = 0, rdy_bad = 0, turn_bad = 0;
    logic [15:0] w;
    wait_ready();
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 1; i < 40; i++) begin
      if (req_ready) break;
      rdy_bad |= req_ready;
      if (!mem_cs_n) begin
        if (first_cs < 0) first_cs = i;
        if (!mem_oe_n) oe_bad = 1;
        if (mem_be_n != ~m) be_bad = 1;
        if (mem_addr != a) addr_bad = 1;
      end else if (first_cs >= 0) turn_bad = 1;
      if (!mem_we_n) begin we_lo++; if (first_we < 0) first_we = i; last_we = i; end
      if (mem_dq_oe) begin if (first_oe < 0) first_oe = i; last_oe = i; end
      @(negedge clk);
    end
    check(we_lo == WP, "R5", "write pulse cycles", we_lo, WP);
    check(!oe_bad, "R5", "output enable high during write", oe_bad, 0);
    check(!be_bad, "R7", "lane enables follow mask", mem_be_n, ~m);
    check(!addr_bad && !turn_bad, "R8", "address held while selected", {addr_bad, turn_bad}, 0);
    check(first_we - first_oe == 1 && last_oe - last_we == 1, "R6", "drive enable lead/trail",
          {first_oe[7:0], first_we[7:0], last_we[7:0], last_oe[7:0]}, 0);
    check(first_cs == lead, "R9", "cycles before chip select", first_cs, lead);
    check(mem_cs_n && mem_we_n && mem_oe_n, "R10", "deselected in idle",
          {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
    w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    if (m[0]) w[7:0] = d[7:0];
    if (m[1]) w[15:8] = d[15:8];
    shadow[int'(a)] = w;
  endtask

  task automatic t_read(input logic [15:0] a, input logic [1:0] m, input string req);
    logic [15:0] exp;
    bit early = 0;
    exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    exp &= {{8{m[1]}}, {8{m[0]}}};
    wait_ready();
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R2", "ready low while busy", req_ready, 0);
    check(!mem_cs_n && !mem_oe_n && mem_we_n && mem_be_n == ~m && mem_addr == a, "R3",
          "read controls", {mem_cs_n, mem_oe_n, mem_we_n, mem_be_n}, {3'b001, ~m});
    for (int i = 1; i <= RW; i++) begin
      if (rsp_valid) early = 1;
      @(negedge clk);
    end
    check(!early && rsp_valid, "R3", "strobe cycle", {early, rsp_valid}, 1);
    check(rsp_rdata == exp, req, "read data", rsp_rdata, exp);
    check(req_ready && mem_cs_n, "R10", "idle after read", {req_ready, mem_cs_n}, 2'b11);
    @(negedge clk);
    check(!rsp_valid, "R3", "strobe one cycle", rsp_valid, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(16'h0000, 16'h1234, 2'b11, 1);
    t_write(16'hFFFF, 16'hBEEF, 2'b11, 1);
    t_read(16'h0000, 2'b11, "R4");
    t_write(16'h0010, 16'hAACD, 2'b01, TA + 1);
    t_write(16'h0010, 16'h55EE, 2'b10, 1);
    t_read(16'h0010, 2'b11, "R7");
    t_write(16'h0000, 16'hEE77, 2'b01, TA + 1);
    t_read(16'h0000, 2'b11, "R7");
    t_read(16'h0000, 2'b10, "R4");
    t_read(16'h0000, 2'b01, "R4");
    t_read(16'hFFFF, 2'b11, "R4");
    t_write(16'hFFFF, 16'h0000, 2'b00, TA + 1);
    t_read(16'hFFFF, 2'b11, "R11");
    t_read(16'hFFFF, 2'b00, "R11");
    check(conflicts == 0, "R6", "bus drive conflicts", conflicts, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule